// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of each beat of an SDRAM read or write burst. A column command pulse captures a starting column together with the burst-length code, the wrap ordering and the write-burst-mode bit. From the following cycle, the block emits one column address per clock. It stops on its own when a fixed-length burst is complete. A full-page burst keeps running until something stops it.

A burst can end early in two ways. A new column command restarts the generator at once. A stop strobe ends the burst after the beat currently shown. Fixed bursts stay inside the aligned block of their own length. The wrap ordering is either a sequential increment of the low column bits or an exclusive-OR of those bits with the beat count. Command issue, bank state and DRAM timing belong to the surrounding controller.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released with no command, `beat_vld_o` and `last_o` are 0.
- R2: After a clock edge at which `start_i` is 1, the next cycle shows `beat_vld_o`=1 and `col_o` equal to the `start_col_i` sampled at that edge (beat 0). Without a command, no beat appears.
- R3: The length code `bl_code_i` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100, 3'b101 and 3'b110 give a single beat.
- R4: With `burst_type_i`=0 and fixed length L, beat k has its upper column bits equal to those of the start column. Its low log2(L) bits equal (start low bits + k) mod L.
- R5: With `burst_type_i`=1 and fixed length L, beat k has its upper column bits equal to those of the start column. Its low log2(L) bits equal start low bits XOR k.
- R6: In full-page mode, beat k is (start + k) mod 2^COL_W (256 columns by default). Beats continue past the wrap with no end until a stop or a new command. `burst_type_i` has no effect in this mode.
- R7: `last_o` is 1 only on the final beat (k = L-1) of a fixed-length burst, never in full-page mode. It is always accompanied by `beat_vld_o`. The cycle after it shows no beat unless a new command arrived.
- R8: When `is_write_i`=1 and `wr_single_i`=1 at the command, the burst is a single beat whatever the length code. For reads, `wr_single_i` has no effect.
- R9: A command arriving during a burst abandons it. The next cycle shows beat 0 of the new burst, with no idle gap, including when the command coincides with the final beat.
- R10: A stop strobe during a beat makes that beat the last one shown. The next cycle has no beat, at every length. A command in the same cycle as a stop takes precedence.
- R11: `start_col_i`, `bl_code_i`, `burst_type_i`, `is_write_i` and `wr_single_i` are sampled only at a command edge. Changes during a burst do not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command (read or write) pulse |
| start_col_i | input | COL_W | Starting column of the burst |
| is_write_i | input | 1 | Command is a write |
| bl_code_i | input | 3 | Burst-length code |
| burst_type_i | input | 1 | Wrap ordering: 0 sequential, 1 interleaved |
| wr_single_i | input | 1 | Write-burst-mode bit: writes are single beat |
| stop_i | input | 1 | Burst stop strobe |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A burst beat is present this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The two functions that meet in one cycle are the arrival of a new column command and the end of a running burst. The end can be its natural last beat or a stop strobe. The bench provokes both overlaps: a command on the cycle that shows the final beat of a 2-beat burst, and a command together with a stop in the middle of an 8-beat burst. In each case it judges that the next cycle shows beat 0 of the new burst with no idle cycle. Around these cases, sweeps over every length code, both orderings, all four write/read and write-mode combinations and many start columns check each beat's address and the last-beat flag arithmetically.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   // Burst-length codes; any other value is treated as a single beat
   typedef enum logic [2:0] {
      BLEN_1    = 3'b000,
      BLEN_2    = 3'b001,
      BLEN_4    = 3'b010,
      BLEN_8    = 3'b011,
      BLEN_PAGE = 3'b111
   } blen_code_e;

   localparam int unsigned MAX_FIXED_LOG2 = 3;
   localparam int unsigned SHIFT_W        = 2;

endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
   import sdram_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [2:0]       bl_code_i,
   input  logic             is_write_i,
   input  logic             wr_single_i,
   input  logic             il_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output logic             il_o
);

   logic [SHIFT_W-1:0] lg2;
   logic               page;
   logic               force_one;

   assign force_one = is_write_i & wr_single_i;

   always_comb begin
      page = 1'b0;
      lg2  = '0;
      case (bl_code_i)
         BLEN_2:    lg2 = SHIFT_W'(1);
         BLEN_4:    lg2 = SHIFT_W'(2);
         BLEN_8:    lg2 = SHIFT_W'(MAX_FIXED_LOG2);
         BLEN_PAGE: page = 1'b1;
         default:   lg2 = '0;
      endcase
      if (force_one) begin
         page = 1'b0;
         lg2  = '0;
      end
   end

   assign full_o = page;
   assign mask_o = page ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << lg2);
   // Full page always increments linearly
   assign il_o   = il_i & ~page;

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   output logic             active_o,
   output logic             last_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] mask_o
);

   logic             active_q;
   logic             full_q;
   logic [COL_W-1:0] cnt_q;
   logic [COL_W-1:0] mask_q;
   logic             at_end;

   assign at_end = active_q & ~full_q & (cnt_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         full_q   <= 1'b0;
         cnt_q    <= '0;
         mask_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         full_q   <= full_i;
         cnt_q    <= '0;
         mask_q   <= mask_i;
      end else if (active_q) begin
         if (stop_i || at_end) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + COL_W'(1);
         end
      end
   end

   assign active_o = active_q;
   assign last_o   = at_end;
   assign cnt_o    = cnt_q;
   assign mask_o   = mask_q;

endmodule

// File: rtl/colgen_col_map.sv
module colgen_col_map #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             il_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;

   // Carries out of the masked low field only reach bits that keep base
   assign sum = base_i + cnt_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
         if (!mask_i[b])
            col_o[b] = base_i[b];
         else if (il_i)
            col_o[b] = base_i[b] ^ cnt_i[b];
         else
            col_o[b] = sum[b];
      end
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             is_write_i,
   input  logic [2:0]       bl_code_i,
   input  logic             burst_type_i,
   input  logic             wr_single_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             beat_vld_o,
   output logic             last_o
);

   localparam int unsigned MIN_COLS = 1 << MAX_FIXED_LOG2;

   if (COL_W < MAX_FIXED_LOG2) begin : g_bad_width
      $error("COL_W must hold the longest fixed burst of %0d beats", MIN_COLS);
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic             dec_il;
   logic [COL_W-1:0] base_q;
   logic             il_q;
   logic [COL_W-1:0] cnt;
   logic [COL_W-1:0] mask;
   logic             active;
   logic             at_end;

   colgen_len_dec #(.COL_W(COL_W)) u_dec (
      .bl_code_i   (bl_code_i),
      .is_write_i  (is_write_i),
      .wr_single_i (wr_single_i),
      .il_i        (burst_type_i),
      .mask_o      (dec_mask),
      .full_o      (dec_full),
      .il_o        (dec_il)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         il_q   <= 1'b0;
      end else if (start_i) begin
         base_q <= start_col_i;
         il_q   <= dec_il;
      end
   end

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .mask_i   (dec_mask),
      .full_i   (dec_full),
      .active_o (active),
      .last_o   (at_end),
      .cnt_o    (cnt),
      .mask_o   (mask)
   );

   colgen_col_map #(.COL_W(COL_W)) u_map (
      .base_i (base_q),
      .cnt_i  (cnt),
      .mask_i (mask),
      .il_i   (il_q),
      .col_o  (col_o)
   );

   assign beat_vld_o = active;
   assign last_o     = at_end;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
   parameter int unsigned COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             stop_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [COL_W-1:0] col_o,
   input logic             beat_vld_o,
   input logic             last_o
);

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_vld_o && !start_i) |=> !beat_vld_o);

   p_last_has_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> beat_vld_o);

   p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !beat_vld_o);

   p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && beat_vld_o && !start_i) |=> !beat_vld_o);

   p_runs_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && !last_o && !stop_i) |=> beat_vld_o);

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && beat_vld_o) |=> (beat_vld_o && col_o == $past(start_col_i)));

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .stop_i      (stop_i),
   .start_col_i (start_col_i),
   .col_o       (col_o),
   .beat_vld_o  (beat_vld_o),
   .last_o      (last_o)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;

   localparam int COL_W = 8;
   localparam int NCOL  = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic             is_write_i = 1'b0;
   logic [2:0]       bl_code_i = 3'b000;
   logic             burst_type_i = 1'b0;
   logic             wr_single_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             beat_vld_o;
   logic             last_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdram_burst_colgen #(.COL_W(COL_W)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_col_i  (start_col_i),
      .is_write_i   (is_write_i),
      .bl_code_i    (bl_code_i),
      .burst_type_i (burst_type_i),
      .wr_single_i  (wr_single_i),
      .stop_i       (stop_i),
      .col_o        (col_o),
      .beat_vld_o   (beat_vld_o),
      .last_o       (last_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                  req, act, act, exp, exp, $time);
      end
   endtask

   function automatic int blen(input int code, input int wr, input int ws);
      if (wr != 0 && ws != 0) return 1;
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         7: return 0;   // full page
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int sc, input int k, input int len, input int il);
      int m;
      if (len == 0) return (sc + k) % NCOL;
      m = len - 1;
      if (il != 0) return (sc & ~m) | ((sc ^ k) & m);
      return (sc & ~m) | ((sc + k) & m);
   endfunction

   task automatic issue(input int code, input int il, input int wr, input int ws, input int sc);
      start_i      = 1'b1;
      start_col_i  = COL_W'(sc);
      bl_code_i    = 3'(code);
      burst_type_i = 1'(il);
      is_write_i   = 1'(wr);
      wr_single_i  = 1'(ws);
   endtask

   // Entered at the negedge showing beat k0; checks through the idle cycle after the end
   task automatic follow(input int code, input int il, input int wr, input int ws,
                         input int sc, input int stopk, input int k0);
      int  len;
      bit  done;
      string ctag;
      len = blen(code, wr, ws);
      ctag = (len == 0) ? "R6" : ((il != 0) ? "R5" : "R4");
      // R11: scramble every sampled input for the rest of the burst
      start_col_i  = ~COL_W'(sc);
      bl_code_i    = ~3'(code);
      burst_type_i = ~1'(il);
      is_write_i   = ~1'(wr);
      wr_single_i  = ~1'(ws);
      for (int k = k0; ; k++) begin
         chk((wr != 0 && ws != 0) ? "R8 beat" : "R3 beat", int'(beat_vld_o), 1);
         chk((k == 0) ? "R2 first column" : {ctag, " column R11"},
             int'(col_o), exp_col(sc, k, len, il));
         chk("R7 last flag", int'(last_o), (len != 0 && k == len - 1) ? 1 : 0);
         done = (k == stopk) || (len != 0 && k == len - 1);
         if (k == stopk) stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
         if (done) break;
      end
      chk(stopk >= 0 ? "R10 stopped" : "R3 burst end", int'(beat_vld_o), 0);
      chk("R7 last after end", int'(last_o), 0);
   endtask

   task automatic burst(input int code, input int il, input int wr, input int ws,
                        input int sc, input int stopk);
      issue(code, il, wr, ws, sc);
      @(negedge clk);
      start_i = 1'b0;
      follow(code, il, wr, ws, sc, stopk, 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 vld in reset", int'(beat_vld_o), 0);
      chk("R1 last in reset", int'(last_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 vld idle", int'(beat_vld_o), 0);
      chk("R1 last idle", int'(last_o), 0);

      // Sweep fixed codes, orderings, write modes and start columns (R3 R4 R5 R8 R11)
      for (int code = 0; code < 7; code++)
         for (int il = 0; il < 2; il++)
            for (int md = 0; md < 4; md++)
               for (int sc = 0; sc < NCOL; sc += 5)
                  burst(code, il, md >> 1, md & 1, sc,
                        (code == 3 && il == 1 && md == 0) ? sc % 8 : -1);

      // R10: stop at beat 0 for every length
      for (int code = 0; code < 8; code++)
         burst(code, 0, 0, 0, 8'h5A, 0);

      // R6: full page wraps and runs until stopped; ordering ignored
      burst(7, 0, 0, 0, 250, 300);
      burst(7, 1, 0, 0, 3, 260);
      burst(7, 1, 1, 0, 128, 20);
      // R8: full-page write with single-beat writes
      burst(7, 0, 1, 1, 77, -1);

      // R9 and R10: command coincides with a stop in mid burst; command wins
      issue(3, 0, 0, 0, 8'h35);
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 first column", int'(col_o), 8'h35);
      @(negedge clk);
      chk("R4 column", int'(col_o), 8'h36);
      issue(2, 1, 0, 0, 8'hC2);
      stop_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      stop_i  = 1'b0;
      follow(2, 1, 0, 0, 8'hC2, -1, 0);   // R9 restart beats C2 C3 C0 C1

      // R9: command on the final beat, no idle gap
      issue(1, 0, 0, 0, 8'h1F);
      @(negedge clk);
      start_i = 1'b0;
      chk("R4 column", int'(col_o), 8'h1F);
      @(negedge clk);
      chk("R4 wrap column", int'(col_o), 8'h1E);
      chk("R7 last flag", int'(last_o), 1);
      issue(0, 0, 1, 0, 8'h80);
      @(negedge clk);
      start_i = 1'b0;
      follow(0, 0, 1, 0, 8'h80, -1, 0);

      // R1 / R2: still idle afterwards
      repeat (2) @(negedge clk);
      chk("R2 no spurious beat", int'(beat_vld_o), 0);

      finish_run();
   end

endmodule